// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Result Pair Registers

This block performs 32-bit integer multiplication and division for a processor core. It keeps results in two registers: a low word (LO) and a high word (HI). A command carries a kind code and two operands. A multiply leaves the 64-bit product split across HI and LO. A divide leaves the quotient in LO and the remainder in HI. The same command port can also load HI or LO directly from the first operand.

The arithmetic result is written in the cycle after issue. A busy counter then models how long real hardware would take to finish. Issuing an operation never stalls. Only a read of HI or LO stalls, and only while the counter is nonzero; the `stall` output tells the requester to hold off. A multiply takes 7, 11 or 15 cycles depending on the size of the first operand. A divide takes a fixed 37 cycles. Division by zero and the single signed overflow case give fixed, trap-free results.

Top module: `muldiv_unit`

## Requirements
- R1: Kind 0 (signed multiply) and kind 1 (unsigned multiply) write the 64-bit product of `op_a` and `op_b`: low 32 bits to LO, high 32 bits to HI.
- R2: Kind 2 (signed divide) and kind 3 (unsigned divide) write the quotient to LO and the remainder to HI. Signed division truncates toward zero, and the remainder takes the dividend's sign.
- R3: Unsigned multiply sets the busy count to 15, 11 or 7. The choice depends on z, the leading-zero count of (`op_a` OR 1): z below 11 gives 15, z from 11 to 21 gives 11, and z of 22 or more gives 7.
- R4: Signed multiply uses the same three bands, but z is the leading-zero count of ((`op_a` XOR (`op_a` arithmetically shifted right by 21)) OR 1).
- R5: Either divide sets the busy count to 37.
- R6: The busy count drops by one on every clock edge that issues no multiply or divide, until it reaches zero.
- R7: `stall` is high exactly when `rd_req` is high and the busy count is nonzero. When `stall` is low, `rd_data` is LO for `rd_sel`=0 and HI for `rd_sel`=1.
- R8: A multiply or divide issued while the count is nonzero reloads the count with its own latency. Issuing a command never raises `stall` by itself.
- R9: Kind 4 loads HI and kind 5 loads LO from `op_a` on the next edge, whatever the count. Neither changes the count. Kinds 6 and 7 change nothing.
- R10: Signed division of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R11: A divisor of zero gives HI = dividend. LO is 0xFFFFFFFF for unsigned divide or a non-negative signed dividend, and 1 for a negative signed dividend.
- R12: After synchronous reset, HI, LO and the busy count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present this cycle |
| op_kind | input | 3 | Command kind (0..5 used) |
| op_a | input | 32 | First operand / dividend / direct write data |
| op_b | input | 32 | Second operand / divisor |
| rd_req | input | 1 | Read of HI or LO requested |
| rd_sel | input | 1 | 0 selects LO, 1 selects HI |
| rd_data | output | 32 | Selected result register |
| stall | output | 1 | Read must wait: the busy count is nonzero |

## Verification
The bench measures the exact number of stalled read cycles after each issue. It places first operands at the band edges, including negative signed values whose sign-folded form has many leading zeros, so a design that counts leading zeros of the raw operand shows the wrong latency. Division covers mixed signs, both divide-by-zero forms and the most-negative-by-minus-one case; truncation toward minus infinity, or a missing special case, shows up as a wrong LO or HI. A direct HI write in the middle of a divide, and a short multiply issued over a long divide, catch a design that makes direct writes wait or that keeps the old count.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int unsigned XLEN = 32;

    typedef enum logic [2:0] {
        K_MUL_S  = 3'd0,
        K_MUL_U  = 3'd1,
        K_DIV_S  = 3'd2,
        K_DIV_U  = 3'd3,
        K_SET_HI = 3'd4,
        K_SET_LO = 3'd5
    } md_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
    } md_pair_t;

    // Number of zero bits above the highest set bit; XLEN when v is zero.
    function automatic int unsigned lead_zeros(input logic [XLEN-1:0] v);
        int unsigned n;
        n = XLEN;
        for (int unsigned i = 0; i < XLEN; i++) begin
            if (v[i]) n = XLEN - 1 - i;
        end
        return n;
    endfunction

    function automatic logic kind_is_arith(input logic [2:0] k);
        return (k[2] == 1'b0);
    endfunction

endpackage

// File: rtl/muldiv_arith.sv
module muldiv_arith
    import muldiv_pkg::*;
(
    input  logic [2:0]      kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output md_pair_t        res
);
    localparam logic [XLEN-1:0] ALL_ONES = '1;
    localparam logic [XLEN-1:0] ONE      = XLEN'(1);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic signed [2*XLEN-1:0] prod_s;
    logic        [2*XLEN-1:0] prod_u;
    logic signed [XLEN-1:0]   sa, sb, q_s, r_s;
    logic        [XLEN-1:0]   q_u, r_u;

    always_comb begin
        sa     = $signed(a);
        sb     = $signed(b);
        prod_s = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
        prod_u = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
        q_u    = '0;
        r_u    = '0;
        q_s    = '0;
        r_s    = '0;
        if (b != '0) begin
            q_u = a / b;
            r_u = a % b;
            if (!(a == MOST_NEG && b == ALL_ONES)) begin
                q_s = sa / sb;
                r_s = sa % sb;
            end
        end

        res = '0;
        unique case (kind)
            K_MUL_S: res = md_pair_t'(prod_s);
            K_MUL_U: res = md_pair_t'(prod_u);
            K_DIV_S: begin
                if (b == '0) begin
                    res.hi = a;
                    res.lo = a[XLEN-1] ? ONE : ALL_ONES;
                end else if (a == MOST_NEG && b == ALL_ONES) begin
                    res.hi = '0;
                    res.lo = MOST_NEG;
                end else begin
                    res.hi = r_s;
                    res.lo = q_s;
                end
            end
            K_DIV_U: begin
                if (b == '0) begin
                    res.hi = a;
                    res.lo = ALL_ONES;
                end else begin
                    res.hi = r_u;
                    res.lo = q_u;
                end
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/muldiv_busy.sv
module muldiv_busy
    import muldiv_pkg::*;
#(
    parameter int unsigned DIV_LAT    = 37,
    parameter int unsigned MUL_BASE   = 7,
    parameter int unsigned MUL_STEP   = 4,
    parameter int unsigned BAND       = 11,
    parameter int unsigned SIGN_SHIFT = 21,
    parameter int unsigned CW         = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [2:0]      kind,
    input  logic [XLEN-1:0] opnd,
    output logic [CW-1:0]   cnt_q,
    output logic            busy
);
    localparam int unsigned    MAX_BAND = (XLEN - 1) / BAND;
    localparam logic [XLEN-1:0] ONE     = XLEN'(1);

    logic [XLEN-1:0] probe;
    int unsigned     zeros;
    logic [CW-1:0]   lat;

    always_comb begin
        if (kind == K_MUL_S)
            probe = (opnd ^ XLEN'($signed(opnd) >>> SIGN_SHIFT)) | ONE;
        else
            probe = opnd | ONE;
        zeros = lead_zeros(probe);
        if (kind[1])
            lat = CW'(DIV_LAT);
        else
            lat = CW'(MUL_BASE + MUL_STEP * (MAX_BAND - zeros / BAND));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (issue)
            cnt_q <= lat;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  md_pair_t        pair,
    input  logic            set_hi,
    input  logic            set_lo,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] hi_q,
    output logic [XLEN-1:0] lo_q
);
    logic [XLEN-1:0] word_q [2];
    logic [XLEN-1:0] word_new [2];
    logic            word_set [2];

    assign word_new[0] = pair.lo;
    assign word_new[1] = pair.hi;
    assign word_set[0] = set_lo;
    assign word_set[1] = set_hi;

    for (genvar g = 0; g < 2; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[g] <= '0;
            else if (load)
                word_q[g] <= word_new[g];
            else if (word_set[g])
                word_q[g] <= wdata;
        end
    end

    assign lo_q = word_q[0];
    assign hi_q = word_q[1];
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int unsigned DIV_LAT    = 37,
    parameter int unsigned MUL_BASE   = 7,
    parameter int unsigned MUL_STEP   = 4,
    parameter int unsigned BAND       = 11,
    parameter int unsigned SIGN_SHIFT = 21
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_kind,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        rd_req,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        stall
);
    localparam int unsigned MAX_BAND = (XLEN - 1) / BAND;
    localparam int unsigned MUL_MAX  = MUL_BASE + MUL_STEP * MAX_BAND;
    localparam int unsigned LAT_MAX  = (DIV_LAT > MUL_MAX) ? DIV_LAT : MUL_MAX;
    localparam int unsigned CW       = $clog2(LAT_MAX + 1);

    logic            issue;
    logic            set_hi, set_lo;
    md_pair_t        result;
    logic [XLEN-1:0] hi_q, lo_q;
    logic [CW-1:0]   cnt_q;
    logic            busy;

    assign issue  = op_valid && kind_is_arith(op_kind);
    assign set_hi = op_valid && (op_kind == K_SET_HI);
    assign set_lo = op_valid && (op_kind == K_SET_LO);

    muldiv_arith u_arith (
        .kind (op_kind),
        .a    (op_a),
        .b    (op_b),
        .res  (result)
    );

    muldiv_busy #(
        .DIV_LAT    (DIV_LAT),
        .MUL_BASE   (MUL_BASE),
        .MUL_STEP   (MUL_STEP),
        .BAND       (BAND),
        .SIGN_SHIFT (SIGN_SHIFT),
        .CW         (CW)
    ) u_busy (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .kind  (op_kind),
        .opnd  (op_a),
        .cnt_q (cnt_q),
        .busy  (busy)
    );

    muldiv_hilo u_hilo (
        .clk    (clk),
        .rst    (rst),
        .load   (issue),
        .pair   (result),
        .set_hi (set_hi),
        .set_lo (set_lo),
        .wdata  (op_a),
        .hi_q   (hi_q),
        .lo_q   (lo_q)
    );

    assign rd_data = rd_sel ? hi_q : lo_q;
    assign stall   = rd_req && busy;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
    parameter int unsigned CW       = 6,
    parameter int unsigned DIV_LAT  = 37,
    parameter int unsigned MUL_BASE = 7,
    parameter int unsigned MUL_STEP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [2:0]    op_kind,
    input logic [31:0]   op_a,
    input logic          rd_req,
    input logic          stall,
    input logic [31:0]   hi_q,
    input logic [31:0]   lo_q,
    input logic [CW-1:0] cnt_q
);
    logic arith_cmd;
    assign arith_cmd = op_valid && !op_kind[2];

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && hi_q == '0 && lo_q == '0));

    a_r5_div_count: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind[2:1] == 2'b01) |=> (cnt_q == CW'(DIV_LAT)));

    a_r3_mul_band: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind[2:1] == 2'b00) |=>
            (cnt_q == CW'(MUL_BASE) || cnt_q == CW'(MUL_BASE + MUL_STEP) ||
             cnt_q == CW'(MUL_BASE + 2 * MUL_STEP)));

    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !arith_cmd) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    a_r7_stall_only_on_read: assert property (@(posedge clk) disable iff (rst)
        stall |-> (rd_req && cnt_q != '0));

    a_r7_read_when_idle: assert property (@(posedge clk) disable iff (rst)
        (rd_req && cnt_q == '0) |-> !stall);

    a_r9_direct_hi: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd4) |=> (hi_q == $past(op_a) && lo_q == $past(lo_q)));

    a_r9_direct_lo: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd5) |=> (lo_q == $past(op_a) && hi_q == $past(hi_q)));
endmodule

bind muldiv_unit muldiv_chk #(
    .CW       (CW),
    .DIV_LAT  (DIV_LAT),
    .MUL_BASE (MUL_BASE),
    .MUL_STEP (MUL_STEP)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_a     (op_a),
    .rd_req   (rd_req),
    .stall    (stall),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .cnt_q    (cnt_q)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd7;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        rd_req = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        stall;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;

    // reference model state
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;
    int          m_cnt = 0;
    int          seen_stalls = 0;

    muldiv_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_a(op_a), .op_b(op_b), .rd_req(rd_req), .rd_sel(rd_sel),
        .rd_data(rd_data), .stall(stall)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int zcount(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
        return 32;
    endfunction

    function automatic int band_lat(input int z);
        if (z < 11) return 15;
        if (z < 22) return 11;
        return 7;
    endfunction

    function automatic logic [31:0] sra21(input logic [31:0] v);
        logic [31:0] r;
        r = v >> 21;
        if (v[31]) r = r | 32'hFFFF_F800;
        return r;
    endfunction

    // magnitude-based signed division, truncating toward zero
    task automatic sdiv(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] q, output logic [31:0] r);
        longint ma, mb, mq, mr;
        ma = a[31] ? (64'd4294967296 - longint'(a)) : longint'(a);
        mb = b[31] ? (64'd4294967296 - longint'(b)) : longint'(b);
        mq = ma / mb;
        mr = ma - mq * mb;
        q = (a[31] != b[31]) ? 32'(-mq) : 32'(mq);
        r = a[31] ? 32'(-mr) : 32'(mr);
    endtask

    task automatic model_step(input bit v, input logic [2:0] k,
                              input logic [31:0] a, input logic [31:0] b);
        longint unsigned pu;
        longint          ps;
        logic [31:0]     q, r;
        if (v && k < 3'd4) begin
            case (k)
                3'd0: begin
                    ps = longint'($signed(a)) * longint'($signed(b));
                    {m_hi, m_lo} = 64'(ps);
                    m_cnt = band_lat(zcount((a ^ sra21(a)) | 32'd1));
                end
                3'd1: begin
                    pu = longint'({32'd0, a}) * longint'({32'd0, b});
                    {m_hi, m_lo} = 64'(pu);
                    m_cnt = band_lat(zcount(a | 32'd1));
                end
                3'd2: begin
                    if (b == 0) begin
                        m_hi = a;
                        m_lo = a[31] ? 32'd1 : 32'hFFFF_FFFF;
                    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                        m_hi = 0;
                        m_lo = 32'h8000_0000;
                    end else begin
                        sdiv(a, b, q, r);
                        m_lo = q;
                        m_hi = r;
                    end
                    m_cnt = 37;
                end
                default: begin
                    if (b == 0) begin
                        m_hi = a;
                        m_lo = 32'hFFFF_FFFF;
                    end else begin
                        m_lo = a / b;
                        m_hi = a % b;
                    end
                    m_cnt = 37;
                end
            endcase
        end else begin
            if (v && k == 3'd4) m_hi = a;
            if (v && k == 3'd5) m_lo = a;
            if (m_cnt > 0) m_cnt--;
        end
    endtask

    // one clock: drive, compare outputs against model, advance
    task automatic cyc(input bit v, input logic [2:0] k, input logic [31:0] a,
                       input logic [31:0] b, input bit rq, input bit sel, input string tag);
        bit          exp_stall;
        logic [31:0] exp_data;
        op_valid = v; op_kind = k; op_a = a; op_b = b; rd_req = rq; rd_sel = sel;
        #1;
        exp_stall = rq && (m_cnt != 0);
        exp_data  = sel ? m_hi : m_lo;
        vectors++;
        if (stall !== exp_stall) begin
            misses++;
            $display("FAIL %s stall: actual %0b expected %0b", tag, stall, exp_stall);
        end else if (rq && !exp_stall && rd_data !== exp_data) begin
            misses++;
            $display("FAIL %s rd_data sel=%0d: actual %h expected %h", tag, sel, rd_data, exp_data);
        end
        if (stall) seen_stalls++;
        @(posedge clk);
        model_step(v, k, a, b);
        @(negedge clk);
        op_valid = 1'b0; rd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'd7, 0, 0, 0, 0, "R6");
    endtask

    // issue, then read until the result is returned, checking stall length
    task automatic run_op(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b,
                          input int exp_lat, input string tag, input string lat_tag);
        cyc(1, k, a, b, 0, 0, tag);
        seen_stalls = 0;
        for (int i = 0; i < 60 && m_cnt != 0; i++) cyc(0, 3'd7, 0, 0, 1, 0, tag);
        vectors++;
        if (seen_stalls != exp_lat) begin
            misses++;
            $display("FAIL %s latency: actual %0d expected %0d", lat_tag, seen_stalls, exp_lat);
        end
        cyc(0, 3'd7, 0, 0, 1, 0, tag);
        cyc(0, 3'd7, 0, 0, 1, 1, tag);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                misses++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset values
        cyc(0, 3'd7, 0, 0, 1, 0, "R12");
        cyc(0, 3'd7, 0, 0, 1, 1, "R12");

        // R1 R3: unsigned multiply, three bands
        run_op(3'd1, 32'd5, 32'd7, 7, "R1", "R3");
        run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 15, "R1", "R3");
        run_op(3'd1, 32'h0010_0000, 32'd3, 11, "R1", "R3");
        run_op(3'd1, 32'h0000_0200, 32'd9, 7, "R1", "R3");
        // R1 R4: signed multiply, sign-folded operand
        run_op(3'd0, 32'hFFFF_FFFD, 32'd7, 7, "R1", "R4");
        run_op(3'd0, 32'h4000_0000, 32'hFFFF_FFFE, 15, "R1", "R4");
        run_op(3'd0, 32'hFFF0_0000, 32'h0000_1234, 11, "R1", "R4");
        // R2 R5: division with mixed signs
        run_op(3'd3, 32'd100, 32'd7, 37, "R2", "R5");
        run_op(3'd2, 32'hFFFF_FFF9, 32'd2, 37, "R2", "R5");
        run_op(3'd2, 32'd7, 32'hFFFF_FFFE, 37, "R2", "R5");
        run_op(3'd3, 32'hFFFF_FFF9, 32'd2, 37, "R2", "R5");
        // R10: overflow case
        run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 37, "R10", "R5");
        // R11: divide by zero
        run_op(3'd3, 32'd5, 32'd0, 37, "R11", "R5");
        run_op(3'd2, 32'hFFFF_FFFB, 32'd0, 37, "R11", "R5");
        run_op(3'd2, 32'd5, 32'd0, 37, "R11", "R5");

        // R9: direct write of HI during a divide, count unaffected
        cyc(1, 3'd3, 32'd50, 32'd8, 0, 0, "R9");
        cyc(1, 3'd4, 32'h0000_ABCD, 0, 1, 1, "R9");
        seen_stalls = 0;
        for (int i = 0; i < 60 && m_cnt != 0; i++) cyc(0, 3'd7, 0, 0, 1, 1, "R9");
        vectors++;
        if (seen_stalls != 36) begin
            misses++;
            $display("FAIL R9 count after direct write: actual %0d expected %0d", seen_stalls, 36);
        end
        cyc(0, 3'd7, 0, 0, 1, 1, "R9");
        cyc(0, 3'd7, 0, 0, 1, 0, "R9");
        // R9: direct LO write while idle, readable next cycle; kinds 6,7 inert
        cyc(1, 3'd5, 32'h1357_9BDF, 0, 0, 0, "R9");
        cyc(1, 3'd6, 32'hDEAD_BEEF, 32'd1, 1, 0, "R9");
        cyc(1, 3'd7, 32'hDEAD_BEEF, 32'd1, 1, 1, "R9");
        cyc(0, 3'd7, 0, 0, 1, 0, "R9");

        // R8: short multiply over a long divide restarts the count
        cyc(1, 3'd3, 32'd1000, 32'd3, 0, 0, "R8");
        idle(3);
        run_op(3'd1, 32'd1, 32'd77, 7, "R8", "R8");
        // R7: issuing while busy without a read never stalls
        cyc(1, 3'd2, 32'd9, 32'd4, 0, 0, "R7");
        cyc(1, 3'd0, 32'd6, 32'd6, 0, 0, "R7");
        idle(20);
        cyc(0, 3'd7, 0, 0, 1, 0, "R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule